// File: doc/BRIEF.md
# Reconfigurable Four-Mode Test Register

This block is an N-stage register that can stand between two pieces of combinational logic and take on one of four roles, chosen by a 2-bit mode code at run time. In functional use it is a plain bank of D flip-flops that captures the parallel data from the logic in front of it. For test it can become a serial shift chain, an autonomous linear-feedback pattern source that drives the logic behind it, or a multiple-input signature compactor that folds the responses of the logic in front of it into a running remainder.

A test controller outside this block sequences the modes. A typical sequence scans a nonzero seed in, generates patterns or compacts responses for a number of cycles, and then scans the signature out. Two such registers on either side of a logic block can swap roles so that each block is tested in turn. The pattern-source and compactor modes share one feedback polynomial, given by the `TAPS` parameter. In that parameter, bit i set means stage i takes part in the feedback XOR.

The mode decoder names its four states MODE_SCAN (00), MODE_GEN (01), MODE_LOAD (10) and MODE_SIG (11). There are no transition conditions between them. Every clock edge applies whichever state the mode input presents, so any state can follow any other.

Top module: `bilbo_reg`

## Requirements
- R1: An active-low asynchronous reset clears every stage to 0, so `par_o` reads 0 and `scan_o` reads 0.
- R2: In mode 00 (MODE_SCAN), stage 0 takes `scan_i` and stage i takes stage i-1 on the next rising edge. `par_i` is ignored.
- R3: In mode 01 (MODE_GEN), stage 0 takes the XOR of all stages whose `TAPS` bit is set, and stage i takes stage i-1. `par_i` and `scan_i` are ignored.
- R4: In mode 10 (MODE_LOAD), every stage i takes `par_i[i]` on the next rising edge. `scan_i` is ignored.
- R5: In mode 11 (MODE_SIG), stage 0 takes the feedback XOR combined with `par_i[0]`, and stage i takes stage i-1 XOR `par_i[i]`.
- R6: `par_o` always presents the stages. `scan_o` always presents the last stage (N-1), in every mode.
- R7: N cycles of mode 00 with `scan_i` held at 0 leave all stages at 0, whatever the earlier contents.
- R8: With the default N=8 and TAPS=8'hB8, mode 01 started from any nonzero state returns to that state after exactly 255 cycles, and never passes through zero or the start state earlier.
- R9: In mode 01, an all-zero state stays all-zero (lock-up).
- R10: A change of mode code takes effect on the very next rising edge, with no idle or transition cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode code: 00 scan, 01 generate, 10 load, 11 signature |
| par_i | input | N | Parallel data from the logic in front of the register |
| scan_i | input | 1 | Serial input to stage 0 in scan mode |
| par_o | output | N | Current stage contents |
| scan_o | output | 1 | Last stage, serial output |

## Verification
Each mode's result is due one rising edge after the mode code and data are presented: `par_o` and `scan_o` show the new state immediately after that edge. The only exception is reset, which acts at once. The bench drives inputs on the falling edge and samples on the next falling edge. It advances a reference model by exactly one step per clock edge, so every comparison lines up with that single-register latency, including when the mode changes between consecutive edges. The longer checks on scan clearing and the 255-cycle period count edges in the bench and compare at the counted edge.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    // Mode code presented on mode_i. The codes are fixed by the controller.
    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_LOAD = 2'b10,
        MODE_SIG  = 2'b11
    } bilbo_mode_e;

    // Per-cycle datapath controls derived from the mode.
    typedef struct packed {
        logic chain;    // stage i takes the previous stage / head bit
        logic head_fb;  // head bit is feedback (1) or scan_i (0)
        logic mix_par;  // XOR parallel input into each stage
    } bilbo_ctl_t;

endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
    import bilbo_pkg::*;
(
    input  logic [1:0] mode_bits,
    output bilbo_mode_e mode,
    output bilbo_ctl_t ctl
);

    assign mode = bilbo_mode_e'(mode_bits);

    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_SCAN: begin
                ctl.chain   = 1'b1;
                ctl.head_fb = 1'b0;
                ctl.mix_par = 1'b0;
            end
            MODE_GEN: begin
                ctl.chain   = 1'b1;
                ctl.head_fb = 1'b1;
                ctl.mix_par = 1'b0;
            end
            MODE_LOAD: begin
                ctl.chain   = 1'b0;
                ctl.head_fb = 1'b0;
                ctl.mix_par = 1'b1;
            end
            MODE_SIG: begin
                ctl.chain   = 1'b1;
                ctl.head_fb = 1'b1;
                ctl.mix_par = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
    parameter int          N    = 8,
    parameter logic [N-1:0] TAPS = 8'hB8
) (
    input  logic [N-1:0] state,
    output logic         fb
);

    logic [N:0] acc;

    assign acc[0] = 1'b0;

    // Only tapped stages get an XOR; the rest pass the partial sum through.
    for (genvar i = 0; i < N; i++) begin : g_tap
        if (TAPS[i]) begin : g_xor
            assign acc[i+1] = acc[i] ^ state[i];
        end else begin : g_pass
            assign acc[i+1] = acc[i];
        end
    end

    assign fb = acc[N];

endmodule

// File: rtl/bilbo_cells.sv
module bilbo_cells
    import bilbo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] state,
    input  logic [N-1:0] par,
    input  logic         head,
    input  bilbo_ctl_t   ctl,
    output logic [N-1:0] nxt
);

    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_cell
        if (i == 0) begin : g_first
            assign prev[i] = head;
        end else begin : g_rest
            assign prev[i] = state[i-1];
        end
        assign nxt[i] = (ctl.chain & prev[i]) ^ (ctl.mix_par & par[i]);
    end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int           N    = 8,
    parameter logic [N-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [N-1:0] par_i,
    input  logic         scan_i,
    output logic [N-1:0] par_o,
    output logic         scan_o
);

    bilbo_mode_e  mode;
    bilbo_ctl_t   ctl;
    logic         fb;
    logic         head;
    logic [N-1:0] stage_q;
    logic [N-1:0] stage_d;

    bilbo_mode_dec u_dec (
        .mode_bits (mode_i),
        .mode      (mode),
        .ctl       (ctl)
    );

    bilbo_feedback #(
        .N    (N),
        .TAPS (TAPS)
    ) u_fb (
        .state (stage_q),
        .fb    (fb)
    );

    assign head = ctl.head_fb ? fb : scan_i;

    bilbo_cells #(
        .N (N)
    ) u_cells (
        .state (stage_q),
        .par   (par_i),
        .head  (head),
        .ctl   (ctl),
        .nxt   (stage_d)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Outputs.
    always_comb begin
        par_o  = stage_q;
        scan_o = stage_q[N-1];
    end

endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
    parameter int           N    = 8,
    parameter logic [N-1:0] TAPS = 8'hB8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_i,
    input logic [N-1:0] par_i,
    input logic         scan_i,
    input logic [N-1:0] par_o,
    input logic         scan_o
);

    // R2
    scan_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b00 |=> par_o == {$past(par_o[N-2:0]), $past(scan_i)});

    // R3
    gen_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b01 |=> par_o == {$past(par_o[N-2:0]), ^($past(par_o) & TAPS)});

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b10 |=> par_o == $past(par_i));

    // R5
    sig_compact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b11 |=> par_o == ({$past(par_o[N-2:0]), ^($past(par_o) & TAPS)} ^ $past(par_i)));

    // R9
    gen_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && par_o == '0) |=> par_o == '0);

    // R6
    scan_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b00 |=> scan_o == $past(par_o[N-2]));

endmodule

bind bilbo_reg bilbo_reg_chk #(
    .N    (N),
    .TAPS (TAPS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .par_i  (par_i),
    .scan_i (scan_i),
    .par_o  (par_o),
    .scan_o (scan_o)
);

// File: tb/test_bilbo_reg.sv
module test_bilbo_reg;

    localparam int          N    = 8;
    localparam logic [N-1:0] TAPS = 8'hB8;
    localparam int          NV   = 16;

    // Each vector: {mode[1:0], par[7:0], scan}
    localparam logic [10:0] VEC [NV] = '{
        {2'b00, 8'hFF, 1'b1},
        {2'b00, 8'h00, 1'b0},
        {2'b00, 8'h5A, 1'b1},
        {2'b01, 8'hFF, 1'b0},
        {2'b01, 8'h33, 1'b1},
        {2'b10, 8'hA5, 1'b1},
        {2'b11, 8'h0F, 1'b0},
        {2'b11, 8'hF0, 1'b1},
        {2'b01, 8'h00, 1'b1},
        {2'b10, 8'h3C, 1'b0},
        {2'b00, 8'hC3, 1'b1},
        {2'b11, 8'h81, 1'b0},
        {2'b11, 8'h7E, 1'b1},
        {2'b01, 8'h55, 1'b0},
        {2'b10, 8'h00, 1'b1},
        {2'b11, 8'h96, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b10;
    logic [N-1:0] par_i = '0;
    logic         scan_i = 1'b0;
    logic [N-1:0] par_o;
    logic         scan_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [N-1:0] model = '0;

    always #4 clk = ~clk;

    bilbo_reg #(.N(N), .TAPS(TAPS)) i_bilbo_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .par_i  (par_i),
        .scan_i (scan_i),
        .par_o  (par_o),
        .scan_o (scan_o)
    );

    function automatic logic [N-1:0] ref_next(logic [N-1:0] s, logic [1:0] m,
                                              logic [N-1:0] d, logic si);
        logic f;
        f = ^(s & TAPS);
        case (m)
            2'b00:   return {s[N-2:0], si};
            2'b01:   return {s[N-2:0], f};
            2'b10:   return d;
            default: return {s[N-2:0], f} ^ d;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, clock, sample at the next falling edge.
    task automatic step(logic [1:0] m, logic [N-1:0] d, logic si);
        mode_i = m;
        par_i  = d;
        scan_i = si;
        model  = ref_next(model, m, d, si);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] seed;
        logic [N-1:0] loaded;
        int first_ret;
        bit saw_zero;

        repeat (2) @(negedge clk);
        // R1: reset state
        check_vec("R1", par_o, '0);
        check_vec("R1 scan_o", {{(N-1){1'b0}}, scan_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, R10: mode changes between consecutive edges
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][10:9], VEC[k][8:1], VEC[k][0]);
            check_vec(tag_of(VEC[k][10:9]), par_o, model);
            check_vec("R6", {{(N-1){1'b0}}, scan_o}, {{(N-1){1'b0}}, model[N-1]});
        end
        check_vec("R10", par_o, model);

        // R6: scan_o shows the loaded word MSB first during scan
        loaded = 8'hB2;
        step(2'b10, loaded, 1'b0);
        for (int k = 0; k < N; k++) begin
            check_vec("R6", {{(N-1){1'b0}}, scan_o}, {{(N-1){1'b0}}, loaded[N-1-k]});
            step(2'b00, 8'hFF, 1'b0);
        end
        // R7: N zero scans clear
        check_vec("R7", par_o, '0);
        step(2'b10, 8'hFF, 1'b0);
        for (int k = 0; k < N; k++) step(2'b00, 8'hFF, 1'b0);
        check_vec("R7", par_o, '0);

        // R9: all-zero state locks up in generate mode
        for (int k = 0; k < 5; k++) step(2'b01, 8'hFF, 1'b1);
        check_vec("R9", par_o, '0);

        // R8: scan in seed 0x01 then count period
        for (int k = 0; k < N; k++) step(2'b00, 8'h00, (k == N - 1));
        seed = 8'h01;
        check_vec("R8 seed", par_o, seed);
        first_ret = 0;
        saw_zero = 0;
        for (int k = 1; k <= 255; k++) begin
            step(2'b01, 8'hA5, 1'b1);
            if (par_o == '0) saw_zero = 1;
            if (par_o == seed && first_ret == 0) first_ret = k;
        end
        check_vec("R8 period", first_ret[7:0], 8'd255);
        check_vec("R8 nonzero", {7'd0, saw_zero}, '0);
        check_vec("R3 model", par_o, model);

        // R5: signature after a burst from a known start
        for (int k = 0; k < 20; k++) step(2'b11, 8'(k * 37 + 11), 1'b1);
        check_vec("R5 burst", par_o, model);

        // R1: asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1 check_vec("R1 async", par_o, '0);
        model = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule